// File: doc/BRIEF.md
# Register Rename Unit with In-Order Commit

This block sits between decode and scheduling in a speculative out-of-order core. For each issued instruction it translates up to two source architectural register numbers into the physical register numbers that currently hold their values. When the instruction writes a result, the block takes an unused physical register for it and points the speculative map at that register. Later readers then see the new copy, and write-after-write and write-after-read hazards disappear.

Every issued instruction is also pushed into an in-order commit queue. Each queue entry records whether the instruction writes a register, the destination architectural number, the newly assigned physical register, and the physical register it displaced. Retirement takes the queue head in program order. It makes the new mapping non-speculative in a separate committed map and gives the displaced register back to the free pool.

A flush discards all speculative work. The speculative map is reloaded from the committed map, the commit queue is emptied, and the free pool is rebuilt from the registers that the committed map does not reference.

Top module: `rn_rename_unit`

## Requirements
- R1: After reset, architectural register i maps to physical register i in both maps for every i below ARCH_REGS. Physical registers ARCH_REGS up to PHYS_REGS-1 are free, the commit queue is empty (`cmt_pending` low) and `iss_ready` is high.
- R2: `iss_psrc1` and `iss_psrc2` give the speculative mapping of `iss_src1` and `iss_src2`, including renames made by earlier issued instructions.
- R3: `iss_pdst` shows the lowest-numbered free physical register and `iss_pold` shows the current speculative mapping of `iss_dst`. An issue (`iss_valid` and `iss_ready`) with `iss_has_dst` high takes `iss_pdst` from the free pool and maps `iss_dst` to it from the next cycle. An issue with `iss_has_dst` low takes no register.
- R4: A source that names the same architectural register as the destination of the same instruction returns the mapping from before that instruction's rename.
- R5: Every issue appends one entry to the commit queue, whether or not it has a destination. While the queue is not empty, `cmt_pending` is high and `cmt_has_dst`, `cmt_arch`, `cmt_pnew` and `cmt_pold` show the oldest entry. At most one entry retires per cycle, and only in a cycle with `cmt_valid` high.
- R6: Retiring an entry with a destination writes `cmt_pnew` into the committed map at `cmt_arch`. It also returns `cmt_pold` to the free pool, where it can be allocated from the next cycle. Retiring an entry without a destination frees nothing.
- R7: `iss_ready` is low while the queue holds CQ_DEPTH entries, and an issue attempted while `iss_ready` is low has no effect.
- R8: `iss_ready` is low while the free pool is empty.
- R9: In a cycle with `flush` high, `iss_ready` is low and a retirement in that same cycle still takes effect. From the next cycle the speculative map equals the committed map, the queue is empty, and the free pool holds exactly the physical registers that the committed map does not reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | An instruction is offered for renaming |
| iss_has_dst | input | 1 | The offered instruction writes a register |
| iss_dst | input | AW | Destination architectural register |
| iss_src1 | input | AW | First source architectural register |
| iss_src2 | input | AW | Second source architectural register |
| iss_ready | output | 1 | The rename unit accepts an instruction this cycle |
| iss_psrc1 | output | PW | Physical register for the first source |
| iss_psrc2 | output | PW | Physical register for the second source |
| iss_pdst | output | PW | Physical register assigned to the destination |
| iss_pold | output | PW | Physical register previously mapped to the destination |
| cmt_valid | input | 1 | Retire the oldest queue entry this cycle |
| cmt_pending | output | 1 | The commit queue holds at least one entry |
| cmt_has_dst | output | 1 | Oldest entry writes a register |
| cmt_arch | output | AW | Oldest entry's destination architectural register |
| cmt_pnew | output | PW | Oldest entry's newly assigned physical register |
| cmt_pold | output | PW | Oldest entry's displaced physical register |
| flush | input | 1 | Discard all speculative state |

## Verification
The checker tracks queue occupancy on its own and checks on every cycle that `cmt_pending` agrees with it and that a full queue holds `iss_ready` low. It also checks that a new destination register never equals the one it displaces, that a retired entry carries two different registers, that a freshly renamed register is seen by the next lookup, and that a flush empties the queue. Some behaviour only the bench's scenarios can show. That covers the exact allocation order from the free pool and the reuse of a register right after its retirement. It also covers the committed map's contents after a flush, the rebuilt free pool, dropped issues while stalled, and the stall on an empty free pool in a reduced configuration.

// File: rtl/rn_pkg.sv
package rn_pkg;
    localparam int unsigned RN_ARCH_REGS = 32;
    localparam int unsigned RN_PHYS_REGS = 64;
    localparam int unsigned RN_CQ_DEPTH  = 16;
endpackage

// File: rtl/rn_free_pool.sv
module rn_free_pool #(
    parameter int unsigned ARCH_REGS = 32,
    parameter int unsigned PHYS_REGS = 64,
    localparam int unsigned PW = $clog2(PHYS_REGS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 alloc,
    input  logic                 release_en,
    input  logic [PW-1:0]        release_idx,
    input  logic                 rebuild,
    input  logic [PHYS_REGS-1:0] used_mask,
    output logic [PW-1:0]        pick,
    output logic                 empty
);
    typedef struct packed {
        logic [PHYS_REGS-1:0] avail;
    } pool_t;

    pool_t st_d, st_q;

    always_comb begin
        pick = '0;
        for (int i = PHYS_REGS - 1; i >= 0; i--) begin
            if (st_q.avail[i]) pick = PW'(i);
        end
        empty = (st_q.avail == '0);

        st_d = st_q;
        if (rebuild) begin
            st_d.avail = ~used_mask;
        end else begin
            if (alloc) st_d.avail[pick] = 1'b0;
            if (release_en) st_d.avail[release_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < PHYS_REGS; i++) begin
                st_q.avail[i] <= (i >= ARCH_REGS);
            end
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/rn_map_tables.sv
module rn_map_tables #(
    parameter int unsigned ARCH_REGS = 32,
    parameter int unsigned PHYS_REGS = 64,
    localparam int unsigned AW = $clog2(ARCH_REGS),
    localparam int unsigned PW = $clog2(PHYS_REGS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [AW-1:0]        rd_a1,
    input  logic [AW-1:0]        rd_a2,
    input  logic [AW-1:0]        rd_a3,
    output logic [PW-1:0]        rd_p1,
    output logic [PW-1:0]        rd_p2,
    output logic [PW-1:0]        rd_p3,
    input  logic                 spec_we,
    input  logic [AW-1:0]        spec_arch,
    input  logic [PW-1:0]        spec_phys,
    input  logic                 cmt_we,
    input  logic [AW-1:0]        cmt_arch,
    input  logic [PW-1:0]        cmt_phys,
    input  logic                 restore,
    output logic [PHYS_REGS-1:0] cmt_used_next
);
    typedef struct packed {
        logic [ARCH_REGS-1:0][PW-1:0] spec;
        logic [ARCH_REGS-1:0][PW-1:0] comm;
    } maps_t;

    maps_t st_d, st_q;

    assign rd_p1 = st_q.spec[rd_a1];
    assign rd_p2 = st_q.spec[rd_a2];
    assign rd_p3 = st_q.spec[rd_a3];

    always_comb begin
        st_d = st_q;
        if (cmt_we) st_d.comm[cmt_arch] = cmt_phys;
        if (restore) begin
            st_d.spec = st_d.comm;
        end else if (spec_we) begin
            st_d.spec[spec_arch] = spec_phys;
        end

        cmt_used_next = '0;
        for (int a = 0; a < ARCH_REGS; a++) begin
            cmt_used_next[st_d.comm[a]] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < ARCH_REGS; a++) begin
                st_q.spec[a] <= PW'(a);
                st_q.comm[a] <= PW'(a);
            end
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/rn_commit_queue.sv
module rn_commit_queue #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned WIDTH = 18,
    localparam int unsigned QW = $clog2(DEPTH),
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    input  logic             clear,
    output logic [WIDTH-1:0] head_data,
    output logic             full,
    output logic             empty
);
    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] slot;
        logic [QW-1:0]               head;
        logic [QW-1:0]               tail;
        logic [CW-1:0]               count;
    } queue_t;

    queue_t st_d, st_q;

    function automatic logic [QW-1:0] bump(input logic [QW-1:0] p);
        return (p == QW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign head_data = st_q.slot[st_q.head];
    assign full      = (st_q.count == CW'(DEPTH));
    assign empty     = (st_q.count == '0);

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.head  = '0;
            st_d.tail  = '0;
            st_d.count = '0;
        end else begin
            if (push) begin
                st_d.slot[st_q.tail] = push_data;
                st_d.tail = bump(st_q.tail);
            end
            if (pop) st_d.head = bump(st_q.head);
            case ({push, pop})
                2'b10:   st_d.count = st_q.count + 1'b1;
                2'b01:   st_d.count = st_q.count - 1'b1;
                default: st_d.count = st_q.count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/rn_rename_unit.sv
module rn_rename_unit
    import rn_pkg::*;
#(
    parameter int unsigned ARCH_REGS = RN_ARCH_REGS,
    parameter int unsigned PHYS_REGS = RN_PHYS_REGS,
    parameter int unsigned CQ_DEPTH  = RN_CQ_DEPTH,
    localparam int unsigned AW = $clog2(ARCH_REGS),
    localparam int unsigned PW = $clog2(PHYS_REGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          iss_valid,
    input  logic          iss_has_dst,
    input  logic [AW-1:0] iss_dst,
    input  logic [AW-1:0] iss_src1,
    input  logic [AW-1:0] iss_src2,
    output logic          iss_ready,
    output logic [PW-1:0] iss_psrc1,
    output logic [PW-1:0] iss_psrc2,
    output logic [PW-1:0] iss_pdst,
    output logic [PW-1:0] iss_pold,
    input  logic          cmt_valid,
    output logic          cmt_pending,
    output logic          cmt_has_dst,
    output logic [AW-1:0] cmt_arch,
    output logic [PW-1:0] cmt_pnew,
    output logic [PW-1:0] cmt_pold,
    input  logic          flush
);
    localparam int unsigned EW = 1 + AW + 2 * PW;

    typedef struct packed {
        logic          has_dst;
        logic [AW-1:0] arch;
        logic [PW-1:0] pnew;
        logic [PW-1:0] pold;
    } entry_t;

    entry_t                 push_ent, head_ent;
    logic                   q_full, q_empty, pool_empty;
    logic                   issue_fire, alloc_fire, retire_fire, retire_free;
    logic [PHYS_REGS-1:0]   used_next;

    assign iss_ready   = !flush && !q_full && !pool_empty;
    assign issue_fire  = iss_valid && iss_ready;
    assign alloc_fire  = issue_fire && iss_has_dst;
    assign retire_fire = cmt_valid && !q_empty;
    assign retire_free = retire_fire && head_ent.has_dst;

    assign cmt_pending = !q_empty;
    assign cmt_has_dst = head_ent.has_dst;
    assign cmt_arch    = head_ent.arch;
    assign cmt_pnew    = head_ent.pnew;
    assign cmt_pold    = head_ent.pold;

    always_comb begin
        push_ent.has_dst = iss_has_dst;
        push_ent.arch    = iss_dst;
        push_ent.pnew    = iss_pdst;
        push_ent.pold    = iss_pold;
    end

    rn_map_tables #(
        .ARCH_REGS(ARCH_REGS),
        .PHYS_REGS(PHYS_REGS)
    ) u_maps (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_a1        (iss_src1),
        .rd_a2        (iss_src2),
        .rd_a3        (iss_dst),
        .rd_p1        (iss_psrc1),
        .rd_p2        (iss_psrc2),
        .rd_p3        (iss_pold),
        .spec_we      (alloc_fire),
        .spec_arch    (iss_dst),
        .spec_phys    (iss_pdst),
        .cmt_we       (retire_free),
        .cmt_arch     (head_ent.arch),
        .cmt_phys     (head_ent.pnew),
        .restore      (flush),
        .cmt_used_next(used_next)
    );

    rn_free_pool #(
        .ARCH_REGS(ARCH_REGS),
        .PHYS_REGS(PHYS_REGS)
    ) u_pool (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc      (alloc_fire),
        .release_en (retire_free),
        .release_idx(head_ent.pold),
        .rebuild    (flush),
        .used_mask  (used_next),
        .pick       (iss_pdst),
        .empty      (pool_empty)
    );

    rn_commit_queue #(
        .DEPTH(CQ_DEPTH),
        .WIDTH(EW)
    ) u_cq (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (issue_fire),
        .push_data(push_ent),
        .pop      (retire_fire),
        .clear    (flush),
        .head_data(head_ent),
        .full     (q_full),
        .empty    (q_empty)
    );
endmodule

// File: rtl/rn_rename_checker.sv
module rn_rename_checker #(
    parameter int unsigned CQ_DEPTH = 16,
    parameter int unsigned AW = 5,
    parameter int unsigned PW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          iss_valid,
    input logic          iss_ready,
    input logic          iss_has_dst,
    input logic [AW-1:0] iss_dst,
    input logic [AW-1:0] iss_src1,
    input logic [PW-1:0] iss_psrc1,
    input logic [PW-1:0] iss_pdst,
    input logic [PW-1:0] iss_pold,
    input logic          cmt_valid,
    input logic          cmt_pending,
    input logic          cmt_has_dst,
    input logic [PW-1:0] cmt_pnew,
    input logic [PW-1:0] cmt_pold,
    input logic          flush
);
    localparam int unsigned CW = $clog2(CQ_DEPTH + 1);
    logic [CW-1:0] occ_q;
    logic          push, pop;

    assign push = iss_valid && iss_ready;
    assign pop  = cmt_valid && cmt_pending;

    always_ff @(posedge clk) begin
        if (!rst_n || flush) occ_q <= '0;
        else occ_q <= occ_q + CW'(push) - CW'(pop);
    end

    assert_pending_tracks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_pending == (occ_q != '0));

    assert_full_stalls_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_q == CW'(CQ_DEPTH)) |-> !iss_ready);

    assert_new_differs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && iss_has_dst) |-> (iss_pdst != iss_pold));

    assert_lookup_sees_rename_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (push && iss_has_dst) |=>
            ((iss_src1 != $past(iss_dst)) || (iss_psrc1 == $past(iss_pdst))));

    assert_retire_distinct_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && cmt_has_dst) |-> (cmt_pnew != cmt_pold));

    assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !cmt_pending);
endmodule

bind rn_rename_unit rn_rename_checker #(
    .CQ_DEPTH(CQ_DEPTH),
    .AW(AW),
    .PW(PW)
) u_rn_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .iss_valid  (iss_valid),
    .iss_ready  (iss_ready),
    .iss_has_dst(iss_has_dst),
    .iss_dst    (iss_dst),
    .iss_src1   (iss_src1),
    .iss_psrc1  (iss_psrc1),
    .iss_pdst   (iss_pdst),
    .iss_pold   (iss_pold),
    .cmt_valid  (cmt_valid),
    .cmt_pending(cmt_pending),
    .cmt_has_dst(cmt_has_dst),
    .cmt_pnew   (cmt_pnew),
    .cmt_pold   (cmt_pold),
    .flush      (flush)
);

// File: tb/rn_rename_unit_bench.sv
`timescale 1ns/1ps
module rn_rename_unit_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    // main instance
    logic       v, hd, cv, fl;
    logic [4:0] dst, s1, s2;
    logic       rdy, pend, c_hd;
    logic [4:0] c_arch;
    logic [5:0] p1, p2, pd, po, c_new, c_old;

    rn_rename_unit u_rn_rename_unit (
        .clk(clk), .rst_n(rst_n), .iss_valid(v), .iss_has_dst(hd), .iss_dst(dst),
        .iss_src1(s1), .iss_src2(s2), .iss_ready(rdy), .iss_psrc1(p1), .iss_psrc2(p2),
        .iss_pdst(pd), .iss_pold(po), .cmt_valid(cv), .cmt_pending(pend),
        .cmt_has_dst(c_hd), .cmt_arch(c_arch), .cmt_pnew(c_new), .cmt_pold(c_old),
        .flush(fl)
    );

    // reduced instance: only four free registers
    logic       sv_v, sv_cv, s_rdy, s_pend, s_hd;
    logic [4:0] sv_dst, s_arch, s_p1u, s_p2u;
    logic [5:0] s_p1, s_p2, s_pd, s_po, s_new, s_old;

    rn_rename_unit #(.ARCH_REGS(32), .PHYS_REGS(36), .CQ_DEPTH(16)) u_rn_rename_unit_small (
        .clk(clk), .rst_n(rst_n), .iss_valid(sv_v), .iss_has_dst(1'b1), .iss_dst(sv_dst),
        .iss_src1(s_p1u), .iss_src2(s_p2u), .iss_ready(s_rdy), .iss_psrc1(s_p1), .iss_psrc2(s_p2),
        .iss_pdst(s_pd), .iss_pold(s_po), .cmt_valid(sv_cv), .cmt_pending(s_pend),
        .cmt_has_dst(s_hd), .cmt_arch(s_arch), .cmt_pnew(s_new), .cmt_pold(s_old),
        .flush(1'b0)
    );
    assign s_p1u = 5'd0;
    assign s_p2u = 5'd0;

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic idle();
        v = 0; hd = 0; dst = 0; s1 = 0; s2 = 0; cv = 0; fl = 0;
        sv_v = 0; sv_dst = 0; sv_cv = 0;
    endtask

    // set issue inputs after a falling edge, settle, let caller check, then clock
    task automatic present(input logic valid, input logic has, input int d, input int a, input int b);
        @(negedge clk);
        idle();
        v = valid; hd = has; dst = 5'(d); s1 = 5'(a); s2 = 5'(b);
        #1;
    endtask

    task automatic t_reset();
        @(negedge clk); idle(); #1;
        check("R1", "ready after reset", int'(rdy), 1);
        check("R1", "pending after reset", int'(pend), 0);
        s1 = 5'd5; s2 = 5'd31; #1;
        check("R1", "identity map src1", int'(p1), 5);
        check("R1", "identity map src2", int'(p2), 31);
        check("R1", "first free", int'(pd), 32);
    endtask

    task automatic t_rename_chain();
        present(1, 1, 3, 3, 4);
        check("R4", "src equal dst pre-rename", int'(p1), 3);
        check("R2", "src2 lookup", int'(p2), 4);
        check("R3", "pdst first", int'(pd), 32);
        check("R3", "pold r3", int'(po), 3);
        present(1, 1, 5, 3, 0);
        check("R2", "src sees rename", int'(p1), 32);
        check("R3", "pdst second", int'(pd), 33);
        check("R3", "pold r5", int'(po), 5);
        present(1, 0, 0, 5, 3);
        check("R2", "src r5 renamed", int'(p1), 33);
        present(1, 1, 3, 0, 0);
        check("R3", "no-dst took no register", int'(pd), 34);
        check("R3", "pold r3 renamed", int'(po), 32);
        // hold commit off: queue must not move
        present(0, 0, 0, 0, 0);
        @(negedge clk); #1;
        check("R5", "pending with cmt_valid low", int'(pend), 1);
        check("R5", "head arch held", int'(c_arch), 3);
        check("R5", "head pnew held", int'(c_new), 32);
        check("R5", "head pold held", int'(c_old), 3);
    endtask

    task automatic t_commit();
        @(negedge clk); idle(); cv = 1; #1;
        check("R5", "head has_dst", int'(c_hd), 1);
        @(negedge clk); #1;
        check("R5", "second head arch", int'(c_arch), 5);
        check("R5", "second head pnew", int'(c_new), 33);
        check("R6", "retired pold reused lowest", int'(pd), 3);
        @(negedge clk); #1;
        check("R5", "third head no-dst", int'(c_hd), 0);
        @(negedge clk); cv = 0; #1;
        check("R6", "no-dst retire frees nothing", int'(pd), 3);
        check("R5", "fourth head pnew", int'(c_new), 34);
    endtask

    task automatic t_flush();
        present(1, 1, 7, 0, 0);
        check("R6", "reuse r3 physical", int'(pd), 3);
        present(1, 1, 8, 0, 0);
        check("R6", "reuse r5 physical", int'(pd), 5);
        @(negedge clk); idle(); fl = 1; v = 1; hd = 1; dst = 5'd9; #1;
        check("R9", "ready low during flush", int'(rdy), 0);
        @(negedge clk); idle(); #1;
        check("R9", "queue empty after flush", int'(pend), 0);
        s1 = 5'd3; s2 = 5'd7; #1;
        check("R9", "r3 committed map", int'(p1), 32);
        check("R9", "r7 restored", int'(p2), 7);
        s1 = 5'd5; s2 = 5'd9; #1;
        check("R9", "r5 committed map", int'(p1), 33);
        check("R9", "r9 untouched by stalled issue", int'(p2), 9);
        check("R9", "rebuilt pool lowest", int'(pd), 3);
    endtask

    task automatic t_full();
        int pops = 0;
        for (int i = 0; i < 16; i++) begin
            present(1, 1, 1, 0, 0);
            check("R7", "ready before full", int'(rdy), 1);
        end
        present(1, 1, 1, 0, 0);
        check("R7", "ready low at full", int'(rdy), 0);
        present(1, 1, 1, 0, 0);
        check("R7", "ready stays low", int'(rdy), 0);
        @(negedge clk); idle(); cv = 1;
        for (int i = 0; i < 20; i++) begin
            #1;
            if (pend) begin
                pops++;
                check("R5", "full-run head arch", int'(c_arch), 1);
            end
            @(negedge clk);
        end
        idle(); #1;
        check("R7", "entries retired after stall", pops, 16);
        check("R7", "queue empty", int'(pend), 0);
    endtask

    task automatic t_pool_empty();
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); idle(); sv_v = 1; sv_dst = 5'(2 + i); #1;
            check("R8", "small ready with free", int'(s_rdy), 1);
            check("R3", "small pdst", int'(s_pd), 32 + i);
        end
        @(negedge clk); idle(); sv_v = 1; sv_dst = 5'd9; #1;
        check("R8", "ready low with empty pool", int'(s_rdy), 0);
        @(negedge clk); idle(); sv_cv = 1; #1;
        check("R6", "small head pold", int'(s_old), 2);
        @(negedge clk); idle(); #1;
        check("R8", "ready back after retire", int'(s_rdy), 1);
        check("R6", "freed register offered", int'(s_pd), 2);
    endtask

    initial begin
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        t_reset();
        t_rename_chain();
        t_commit();
        t_flush();
        t_full();
        t_pool_empty();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        #100000;
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule